// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits in front of a single processor and presents at most one external interrupt to it at a time. Interrupt sources offer a source number together with an 8-bit priority. The block keeps the offer only if it beats both the processor's current priority and whatever is already waiting. An offer that loses is handed straight back to its sender on a reject port. A waiting source that is pushed out by a better offer is handed back the same way. A single level output tells the processor that something is waiting.

The processor drives the block through a one-cycle command port. It can take the waiting interrupt, signal end of service, raise or lower its current priority, post an inter-processor interrupt request at a given priority, or read the state without changing it. The current priority and the waiting source number are kept together in one 32-bit word: priority in the top byte, source in the low 24 bits. A source field of zero means nothing is waiting.

End-of-service notices are forwarded to the sources. When the block becomes able to take new work, it pulses a resend request so that the sources offer again anything they had parked. The inter-processor request uses the fixed source number 2. It can displace a waiting external interrupt of lower urgency.

Top module: `irq_presenter`

## Requirements
- R1: After reset the output line is low, a poll returns word 0x00000000 and IPI request value 0xFF, and no reject, EOI or resend pulse is present.
- R2: The state word holds the current priority in bits 31:24 and the waiting source in bits 23:0. Source 0 means empty. A smaller priority value is more urgent, and 0xFF means none.
- R3: An offer (src, prio) is rejected by a reject pulse carrying src when prio >= current priority, or when a source is waiting whose pending priority <= prio. State and the output line are then unchanged.
- R4: An offer that is not rejected latches src and prio as pending and raises the output line. A waiting source that came from an offer is rejected in the same cycle. A waiting IPI is dropped with no reject.
- R5: Command accept (op 1) returns the old state word and lowers the line. It then sets current priority to the pending priority, clears the source field and sets pending priority to 0xFF.
- R6: Command set-priority (op 3, value in data bits 7:0) with a more urgent value, while a source waits with new value <= pending priority, clears the source and sets pending to 0xFF. It lowers the line and rejects the source if that source came from an offer.
- R7: Set-priority with a value that is not more urgent, while nothing waits, pulses resend. If the IPI request value is below the new priority, the IPI is loaded as pending (source 2, pending priority = request) and the line is raised.
- R8: Command set-IPI (op 4, value in data bits 7:0) stores the request value. If the value is below the current priority and no waiting source has pending priority <= value, any waiting offered source is rejected and the IPI is loaded and raised.
- R9: Command EOI (op 2) loads current priority from data bits 31:24 and pulses an EOI carrying data bits 23:0. If nothing waits, a resend with the IPI check of R7 follows in the same cycle.
- R10: Command poll (op 5) returns the state word and IPI request value and changes no state.
- R11: An offer with source 0 is ignored. Offers are taken only in cycles with no command; offer_ready is low while cmd_valid is high, and an offer presented then has no effect.
- R12: All outputs are registered. Responses, reject, EOI and resend appear in the cycle after the command or offer, and each pulse lasts one cycle unless the next input causes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | A source offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer is taken this cycle (no command present) |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | 1 accept, 2 EOI, 3 set priority, 4 set IPI, 5 poll |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Response to accept or poll |
| rsp_word | output | 32 | Returned state word |
| rsp_ipi | output | 8 | Returned IPI request value (poll) |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | A source is handed back |
| reject_src | output | 24 | Source number handed back |
| eoi_valid | output | 1 | End-of-service notice |
| eoi_src | output | 24 | Source of the EOI notice |
| resend_req | output | 1 | Ask the sources to offer again |

## Verification
Directed offers are run against an empty slot, an equal pending priority, a more urgent pending priority, and a waiting IPI. These separate the two reject conditions from displacement, and displacement of an offered source from silent replacement of an IPI. Priority writes are tried in both directions with and without a waiting source, which separates clearing from resending. EOI with an empty slot and a low IPI request shows whether resend carries the IPI check. A long seeded random mix of offers and commands with small source numbers then hits repeated displacement and back-to-back pulses, and every cycle is compared against a bench model.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_ACCEPT   = 3'd1,
        CMD_EOI      = 3'd2,
        CMD_SET_PRIO = 3'd3,
        CMD_SET_IPI  = 3'd4,
        CMD_POLL     = 3'd5
    } irqp_cmd_e;

endpackage

// File: rtl/irqp_offer_judge.sv
module irqp_offer_judge #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input  logic              offer_go,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              take,
    output logic              lose
);
    logic real_offer;
    logic beaten;

    always_comb begin
        real_offer = offer_go && (offer_src != '0);
        beaten     = (offer_prio >= cur_prio) ||
                     ((pend_src != '0) && (pend_prio <= offer_prio));
        take       = real_offer && !beaten;
        lose       = real_offer && beaten;
    end
endmodule

// File: rtl/irqp_ipi_check.sv
module irqp_ipi_check #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              fire
);
    always_comb begin
        fire = !((pend_src != '0) && (pend_prio <= req_prio));
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    output logic                      offer_ready,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [SRC_W+PRIO_W-1:0]   cmd_data,
    output logic                      rsp_valid,
    output logic [SRC_W+PRIO_W-1:0]   rsp_word,
    output logic [PRIO_W-1:0]         rsp_ipi,
    output logic                      irq_out,
    output logic                      reject_valid,
    output logic [SRC_W-1:0]          reject_src,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_req
);
    localparam int REG_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cur;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] ipi;
        logic              ext;
        logic              irq;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
        logic              rsp_v;
        logic [REG_W-1:0]  rsp_word;
        logic [PRIO_W-1:0] rsp_ipi;
    } pres_state_t;

    pres_state_t s_q, s_d;

    irqp_cmd_e         op;
    logic [PRIO_W-1:0] new_prio;
    logic [PRIO_W-1:0] eoi_prio;
    logic [PRIO_W-1:0] ipi_sel;
    logic              offer_go;
    logic              offer_take;
    logic              offer_lose;
    logic              ipi_fire;
    logic              do_resend;
    logic              ipi_go;

    assign op          = cmd_valid ? irqp_cmd_e'(cmd_op) : CMD_NONE;
    assign new_prio    = cmd_data[PRIO_W-1:0];
    assign eoi_prio    = cmd_data[REG_W-1 -: PRIO_W];
    assign ipi_sel     = (op == CMD_SET_IPI) ? new_prio : s_q.ipi;
    assign offer_go    = offer_valid && !cmd_valid;
    assign offer_ready = !cmd_valid;

    irqp_offer_judge #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) judge_i (
        .offer_go   (offer_go),
        .offer_src  (offer_src),
        .offer_prio (offer_prio),
        .cur_prio   (s_q.cur),
        .pend_src   (s_q.src),
        .pend_prio  (s_q.pend),
        .take       (offer_take),
        .lose       (offer_lose)
    );

    irqp_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) ipi_i (
        .req_prio  (ipi_sel),
        .pend_src  (s_q.src),
        .pend_prio (s_q.pend),
        .fire      (ipi_fire)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rej_v    = 1'b0;
        s_d.rej_src  = '0;
        s_d.eoi_v    = 1'b0;
        s_d.eoi_src  = '0;
        s_d.resend   = 1'b0;
        s_d.rsp_v    = 1'b0;
        s_d.rsp_word = '0;
        s_d.rsp_ipi  = '0;
        do_resend    = 1'b0;
        ipi_go       = 1'b0;

        case (op)
            CMD_ACCEPT: begin
                s_d.rsp_v    = 1'b1;
                s_d.rsp_word = {s_q.cur, s_q.src};
                s_d.cur      = s_q.pend;
                s_d.src      = '0;
                s_d.pend     = PRIO_NONE;
                s_d.ext      = 1'b0;
                s_d.irq      = 1'b0;
            end
            CMD_SET_PRIO: begin
                s_d.cur = new_prio;
                if (new_prio < s_q.cur) begin
                    if ((s_q.src != '0) && (new_prio <= s_q.pend)) begin
                        if (s_q.ext) begin
                            s_d.rej_v   = 1'b1;
                            s_d.rej_src = s_q.src;
                        end
                        s_d.src  = '0;
                        s_d.pend = PRIO_NONE;
                        s_d.ext  = 1'b0;
                        s_d.irq  = 1'b0;
                    end
                end else if (s_q.src == '0) begin
                    do_resend = 1'b1;
                end
            end
            CMD_SET_IPI: begin
                s_d.ipi = new_prio;
                if (new_prio < s_q.cur) begin
                    ipi_go = 1'b1;
                end
            end
            CMD_EOI: begin
                s_d.cur     = eoi_prio;
                s_d.eoi_v   = 1'b1;
                s_d.eoi_src = cmd_data[SRC_W-1:0];
                if (s_q.src == '0) begin
                    do_resend = 1'b1;
                end
            end
            CMD_POLL: begin
                s_d.rsp_v    = 1'b1;
                s_d.rsp_word = {s_q.cur, s_q.src};
                s_d.rsp_ipi  = s_q.ipi;
            end
            default: begin
                if (offer_lose) begin
                    s_d.rej_v   = 1'b1;
                    s_d.rej_src = offer_src;
                end else if (offer_take) begin
                    if ((s_q.src != '0) && s_q.ext) begin
                        s_d.rej_v   = 1'b1;
                        s_d.rej_src = s_q.src;
                    end
                    s_d.src  = offer_src;
                    s_d.pend = offer_prio;
                    s_d.ext  = 1'b1;
                    s_d.irq  = 1'b1;
                end
            end
        endcase

        if (do_resend) begin
            s_d.resend = 1'b1;
            if (s_q.ipi < s_d.cur) begin
                ipi_go = 1'b1;
            end
        end

        if (ipi_go && ipi_fire) begin
            if ((s_q.src != '0) && s_q.ext) begin
                s_d.rej_v   = 1'b1;
                s_d.rej_src = s_q.src;
            end
            s_d.src  = SRC_IPI;
            s_d.pend = ipi_sel;
            s_d.ext  = 1'b0;
            s_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.pend <= PRIO_NONE;
            s_q.ipi  <= PRIO_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid    = s_q.rsp_v;
    assign rsp_word     = s_q.rsp_word;
    assign rsp_ipi      = s_q.rsp_ipi;
    assign irq_out      = s_q.irq;
    assign reject_valid = s_q.rej_v;
    assign reject_src   = s_q.rej_src;
    assign eoi_valid    = s_q.eoi_v;
    assign eoi_src      = s_q.eoi_src;
    assign resend_req   = s_q.resend;

    // R2
    line_tracks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq == (s_q.src != '0));

    // R3
    offer_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_lose |=> (reject_valid && (reject_src == $past(offer_src))
                        && $stable(s_q.src) && $stable(s_q.irq)));

    // R4
    offer_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_take |=> (irq_out && (s_q.src == $past(offer_src))
                        && (s_q.pend == $past(offer_prio))));

    // R5
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMD_ACCEPT) |=> (!irq_out && rsp_valid && (s_q.pend == PRIO_NONE)));

    // R10
    poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMD_POLL) |=> ($stable(s_q.cur) && $stable(s_q.src) && $stable(s_q.pend)
                              && $stable(s_q.ipi) && $stable(s_q.irq) && !reject_valid));

    // R11
    offer_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && cmd_valid) |-> !(offer_take || offer_lose));

    // R9
    eoi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMD_EOI) |=> (eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0]))));
endmodule

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_ready;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi;
    logic        irq_out;
    logic        reject_valid;
    logic [23:0] reject_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int errors = 0;
    int checks = 0;

    // bench model of the presenter, from the requirements
    logic [7:0]  m_cur, m_pend, m_ipi;
    logic [23:0] m_src;
    logic        m_ext, m_irq;
    logic        e_rej_v, e_eoi_v, e_resend, e_rsp_v;
    logic [23:0] e_rej_src, e_eoi_src;
    logic [31:0] e_rsp_word;
    logic [7:0]  e_rsp_ipi;

    always #2.5 clk = ~clk;

    irq_presenter dut_i (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_ready(offer_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi),
        .irq_out(irq_out),
        .reject_valid(reject_valid), .reject_src(reject_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_cur = 8'h00; m_src = '0; m_pend = 8'hFF; m_ipi = 8'hFF;
        m_ext = 1'b0; m_irq = 1'b0;
    endtask

    task automatic m_ipi_check();
        if (m_src != 0 && m_pend <= m_ipi) return;
        if (m_src != 0 && m_ext) begin e_rej_v = 1'b1; e_rej_src = m_src; end
        m_src = 24'd2; m_pend = m_ipi; m_ext = 1'b0; m_irq = 1'b1;
    endtask

    task automatic m_resend();
        e_resend = 1'b1;
        if (m_ipi < m_cur) m_ipi_check();
    endtask

    task automatic m_step(input bit cv, input logic [2:0] op, input logic [31:0] data,
                          input bit ov, input logic [23:0] os, input logic [7:0] op_prio);
        logic [7:0] p;
        logic [7:0] old;
        e_rej_v = 0; e_rej_src = 0; e_eoi_v = 0; e_eoi_src = 0;
        e_resend = 0; e_rsp_v = 0; e_rsp_word = 0; e_rsp_ipi = 0;
        p = data[7:0];
        if (cv) begin
            case (op)
                3'd1: begin
                    e_rsp_v = 1; e_rsp_word = {m_cur, m_src};
                    m_cur = m_pend; m_src = 0; m_pend = 8'hFF; m_ext = 0; m_irq = 0;
                end
                3'd2: begin
                    m_cur = data[31:24]; e_eoi_v = 1; e_eoi_src = data[23:0];
                    if (m_src == 0) m_resend();
                end
                3'd3: begin
                    old = m_cur; m_cur = p;
                    if (p < old) begin
                        if (m_src != 0 && p <= m_pend) begin
                            if (m_ext) begin e_rej_v = 1; e_rej_src = m_src; end
                            m_src = 0; m_pend = 8'hFF; m_ext = 0; m_irq = 0;
                        end
                    end else if (m_src == 0) begin
                        m_resend();
                    end
                end
                3'd4: begin
                    m_ipi = p;
                    if (p < m_cur) m_ipi_check();
                end
                3'd5: begin
                    e_rsp_v = 1; e_rsp_word = {m_cur, m_src}; e_rsp_ipi = m_ipi;
                end
                default: ;
            endcase
        end else if (ov && os != 0) begin
            if (op_prio >= m_cur || (m_src != 0 && m_pend <= op_prio)) begin
                e_rej_v = 1; e_rej_src = os;
            end else begin
                if (m_src != 0 && m_ext) begin e_rej_v = 1; e_rej_src = m_src; end
                m_src = os; m_pend = op_prio; m_ext = 1; m_irq = 1;
            end
        end
    endtask

    task automatic step(input bit cv, input logic [2:0] op, input logic [31:0] data,
                        input bit ov, input logic [23:0] os, input logic [7:0] opr,
                        input string tag);
        cmd_valid = cv; cmd_op = op; cmd_data = data;
        offer_valid = ov; offer_src = os; offer_prio = opr;
        #1;
        chk(offer_ready == !cv, tag, "offer_ready", 32'(offer_ready), 32'(!cv));
        m_step(cv, op, data, ov, os, opr);
        @(posedge clk);
        @(negedge clk);
        chk(irq_out == m_irq, tag, "irq_out", 32'(irq_out), 32'(m_irq));
        chk(reject_valid == e_rej_v, tag, "reject_valid", 32'(reject_valid), 32'(e_rej_v));
        if (e_rej_v)
            chk(reject_src == e_rej_src, tag, "reject_src", 32'(reject_src), 32'(e_rej_src));
        chk(eoi_valid == e_eoi_v, tag, "eoi_valid", 32'(eoi_valid), 32'(e_eoi_v));
        if (e_eoi_v)
            chk(eoi_src == e_eoi_src, tag, "eoi_src", 32'(eoi_src), 32'(e_eoi_src));
        chk(resend_req == e_resend, tag, "resend_req", 32'(resend_req), 32'(e_resend));
        chk(rsp_valid == e_rsp_v, tag, "rsp_valid", 32'(rsp_valid), 32'(e_rsp_v));
        if (e_rsp_v) begin
            chk(rsp_word == e_rsp_word, tag, "rsp_word", rsp_word, e_rsp_word);
            if (op == 3'd5)
                chk(rsp_ipi == e_rsp_ipi, tag, "rsp_ipi", 32'(rsp_ipi), 32'(e_rsp_ipi));
        end
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p, input string tag);
        step(1'b0, 3'd0, 32'd0, 1'b1, s, p, tag);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] d, input string tag);
        step(1'b1, op, d, 1'b0, 24'd0, 8'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5EED_1234);
        m_reset();
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk(irq_out == 1'b0, "R1", "irq_out", 32'(irq_out), 32'd0);
        chk(reject_valid == 1'b0 && eoi_valid == 1'b0 && resend_req == 1'b0,
            "R1", "pulses", {29'd0, reject_valid, eoi_valid, resend_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmd(3'd5, 32'd0, "R1");                    // poll: 00000000, ipi FF
        offer(24'd5, 8'h03, "R3");                 // current priority 0 -> reject
        cmd(3'd3, 32'h0000_00FF, "R7");            // less urgent, empty -> resend
        offer(24'd5, 8'h10, "R4");                 // wins
        offer(24'd6, 8'h10, "R3");                 // equal to pending -> reject
        offer(24'd7, 8'h08, "R4");                 // displaces 5
        cmd(3'd5, 32'd0, "R2");                    // FF000007
        cmd(3'd4, 32'h0000_0004, "R8");            // IPI displaces 7
        offer(24'd9, 8'h06, "R3");                 // pending 4 beats 6
        cmd(3'd4, 32'h0000_0005, "R8");            // pending 4 <= 5: no change
        cmd(3'd1, 32'd0, "R5");                    // returns FF000002
        cmd(3'd5, 32'd0, "R10");                   // 04000000, ipi 05
        cmd(3'd5, 32'd0, "R10");                   // repeated poll, same
        offer(24'd0, 8'h01, "R11");                // source 0 ignored
        step(1'b1, 3'd5, 32'd0, 1'b1, 24'd3, 8'h00, "R11"); // offer stalled by poll
        cmd(3'd5, 32'd0, "R11");                   // still empty
        cmd(3'd2, 32'hFF00_0002, "R9");            // EOI, empty -> resend loads IPI 05
        offer(24'h00000A, 8'h01, "R4");            // displaces IPI silently
        cmd(3'd3, 32'h0000_0001, "R6");            // more urgent, clears and rejects A
        cmd(3'd3, 32'h0000_0000, "R6");            // more urgent, nothing pending
        step(1'b0, 3'd0, 32'd0, 1'b0, 24'd0, 8'd0, "R12"); // idle: pulses drop
        cmd(3'd3, 32'h0000_0000, "R7");            // equal (not more urgent), empty -> resend
        offer(24'hFFFFFF, 8'h00, "R3");            // prio 0 >= current 0
        cmd(3'd2, 32'h8000_0044, "R9");            // EOI, ipi 05 < 80 -> IPI loaded
        cmd(3'd2, 32'h2000_0011, "R9");            // EOI with IPI pending: no resend
        cmd(3'd1, 32'd0, "R5");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b, c;
            a = $urandom; b = $urandom; c = $urandom;
            if (a[0]) begin
                logic [23:0] s;
                s = (b[7:0] == 8'hFF) ? 24'hFFFFFF : {20'd0, b[3:0]};
                offer(s, c[1] ? {4'd0, c[7:4]} : c[15:8], "R4");
            end else begin
                logic [2:0] op;
                op = 3'(1 + (a[9:1] % 5));
                cmd(op, {(b[0] ? {4'd0, b[7:4]} : b[15:8]), 20'd0, b[19:16],
                         (c[0] ? {4'd0, c[7:4]} : c[15:8])}, "R12");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule